// File: doc/BRIEF.md
# Byte-Wide SEC-DED Memory Protection Unit

This unit guards a byte-wide memory word against soft errors. On the write side, an 8-bit data byte enters with a valid strobe. One clock later a 13-bit codeword comes out and goes to the array. That codeword holds four Hamming check bits and one overall even-parity bit. On the read side, a fetched 13-bit codeword enters with its own strobe. One clock later the unit returns a result with the recovered byte, the syndrome and two status flags.

Each check bit covers the data positions whose position number has a one in that check bit's binary column. A fetched word therefore yields a syndrome equal to the number of a single flipped position, so the decoder corrects that bit without any lookup. The overall parity bit separates odd error counts from even ones. A nonzero syndrome with matching parity is an uncorrectable double error. A syndrome beyond the last real position is also uncorrectable. The decoder never alters data in either of those cases. The number of check bits K is derived from the data width as the smallest K with 2^K − 1 ≥ M + K. An 8-bit word gets K = 4.

Top module: `ecc_secded_unit`

## Requirements
- R1: Codeword bit 0 is the overall parity bit. Bits 1 to 12 are Hamming positions 1 to 12. Check bit k sits at position 2^k, which gives positions 1, 2, 4 and 8. Data bits 0 (least significant) to 7 sit in ascending order at positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R2: Check bit k is the XOR of the data bits whose position number has bit k set. The overall parity bit makes the count of ones across all 13 codeword bits even.
- R3: The encoder registers its output. `enc_done` is high exactly one cycle after a cycle with `enc_valid` high, and low one cycle after a cycle with `enc_valid` low.
- R4: The decoder registers its output. `dec_done` follows `dec_valid` with one cycle of latency, in the same way as R3.
- R5: `dec_syndrome` is the stored check bits XOR the check bits recomputed from the fetched data bits. An undamaged codeword gives syndrome 0, both flags low, and the original data.
- R6: A single flipped bit in positions 1 to 12 gives a syndrome equal to its position. The unit raises `dec_corrected`, keeps `dec_uncorrectable` low, and returns the original data. For example, data 00111001 with data bit 2 (position 6) flipped gives syndrome 6.
- R7: A flip of the overall parity bit alone gives syndrome 0, raises `dec_corrected`, and returns the data unchanged.
- R8: A nonzero syndrome with even overall parity (a double error) raises `dec_uncorrectable` and keeps `dec_corrected` low. The data returned is the data bits exactly as fetched.
- R9: A syndrome of 13 to 15 with odd overall parity raises `dec_uncorrectable`, and the data returned is exactly as fetched.
- R10: While `rst_n` is low at a clock edge, both done strobes and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_valid | input | 1 | Encode request strobe |
| enc_data | input | 8 | Byte to protect |
| enc_done | output | 1 | Encoded word valid |
| enc_word | output | 13 | Codeword to store |
| dec_valid | input | 1 | Decode request strobe |
| dec_word | input | 13 | Fetched codeword |
| dec_done | output | 1 | Decode result valid |
| dec_data | output | 8 | Recovered byte |
| dec_syndrome | output | 4 | Syndrome of the fetched word |
| dec_corrected | output | 1 | A single error was repaired |
| dec_uncorrectable | output | 1 | Error detected but not repairable |

## Verification
Every cycle, the assertions check the one-cycle strobe latency on both sides and even parity on every emitted codeword. They also check that the two flags are never high together. For a clean word or a detected fatal error, they check that the returned byte equals the fetched data bits. For out-of-range syndromes with odd parity, they check that the uncorrectable flag is raised. Only the bench scenarios can show that the repair lands on the right bit and that the syndrome names the flipped position. The same holds for the exact bit layout of the codeword and the classification of double and triple patterns. The bench builds these from random bytes and chosen flip masks, with the textbook byte and out-of-range triple flips as directed cases.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
// ecc_pkg: layout helpers shared by the SEC-DED unit.
// Assumes data widths of at most 120 bits, so positions stay below 128.
package ecc_pkg;

    typedef enum logic [1:0] {
        DS_CLEAN = 2'd0,
        DS_FIXED = 2'd1,
        DS_FATAL = 2'd2
    } dec_status_e;

    // Smallest check-bit count K with 2^K - 1 >= m + K.
    function automatic int chk_width(input int m);
        int k;
        k = 1;
        while (((1 << k) - 1) < (m + k)) k++;
        return k;
    endfunction

    // True when p is a power of two (a check-bit position).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Hamming position (1-based) that holds data bit idx.
    function automatic int data_pos(input int idx);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int p = 1; p < 128; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx && pos == 0) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction

    // Data bit index held by non-power-of-two position p.
    function automatic int data_idx(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q < p; q++) begin
            if (!is_pow2(q)) cnt++;
        end
        return cnt;
    endfunction

    // Mask of the data bits covered by check bit k.
    function automatic logic [127:0] cover_mask(input int k, input int m);
        logic [127:0] msk;
        msk = '0;
        for (int i = 0; i < m; i++) begin
            if (((data_pos(i) >> k) & 1) == 1) msk[i] = 1'b1;
        end
        return msk;
    endfunction

endpackage

// File: rtl/ecc_checkgen.sv
`timescale 1ns/1ps
// ecc_checkgen: combinational Hamming check-bit generator.
// Each check bit is the parity of the data bits whose position has that
// bit set. Assumes DATA_W <= 120.
module ecc_checkgen #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        localparam logic [127:0] COVER = ecc_pkg::cover_mask(k, DATA_W);
        // parity over the covered data bits
        assign chk_o[k] = ^(data_i & COVER[DATA_W-1:0]);
    end

endmodule

// File: rtl/ecc_encoder.sv
`timescale 1ns/1ps
// ecc_encoder: builds the stored codeword from a data word and registers it.
// Codeword bit 0 is the overall even parity; bits 1..POS_W are Hamming
// positions with the check bits at powers of two. One cycle of latency.
module ecc_encoder #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CW_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [CW_W-1:0]   cw_o
);

    logic [CHK_W-1:0] chk;
    logic [CW_W-1:0]  cw_d;

    ecc_checkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
        .data_i (data_i),
        .chk_o  (chk)
    );

    for (genvar p = 1; p < CW_W; p++) begin : g_pos
        if (ecc_pkg::is_pow2(p)) begin : g_c
            assign cw_d[p] = chk[$clog2(p)];
        end else begin : g_d
            assign cw_d[p] = data_i[ecc_pkg::data_idx(p)];
        end
    end

    assign cw_d[0] = ^cw_d[CW_W-1:1];

    // register the codeword and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            cw_o    <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) cw_o <= cw_d;
        end
    end

    p_even_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (^cw_o) == 1'b0);
    p_enc_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_enc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

endmodule

// File: rtl/ecc_decoder.sv
`timescale 1ns/1ps
// ecc_decoder: checks a fetched codeword, repairs a single error and flags
// uncorrectable ones. Data is left as fetched on any fatal error.
// Output is registered with one cycle of latency.
module ecc_decoder #(
    parameter int DATA_W = 8,
    parameter int CHK_W  = 4,
    parameter int CW_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CW_W-1:0]   cw_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  syn_o,
    output logic              fixed_o,
    output logic              fatal_o
);
    import ecc_pkg::*;

    localparam int POS_W = CW_W - 1;
    localparam logic [CHK_W-1:0] POS_LAST = CHK_W'(POS_W);

    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] fix_data;
    logic [CHK_W-1:0]  rx_chk;
    logic [CHK_W-1:0]  re_chk;
    logic [CHK_W-1:0]  syn;
    logic              par_bad;
    logic              flip_en;
    dec_status_e       status;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rx
        assign rx_data[i] = cw_i[data_pos(i)];
    end

    for (genvar k = 0; k < CHK_W; k++) begin : g_rc
        assign rx_chk[k] = cw_i[1 << k];
    end

    ecc_checkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
        .data_i (rx_data),
        .chk_o  (re_chk)
    );

    assign syn     = rx_chk ^ re_chk;
    assign par_bad = ^cw_i;

    // classify the fetched word from syndrome and overall parity
    always_comb begin
        if (syn == '0) begin
            status = par_bad ? DS_FIXED : DS_CLEAN;
        end else if (!par_bad) begin
            status = DS_FATAL;
        end else if (syn > POS_LAST) begin
            status = DS_FATAL;
        end else begin
            status = DS_FIXED;
        end
    end

    assign flip_en = (status == DS_FIXED) && (syn != '0);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam logic [CHK_W-1:0] DPOS = CHK_W'(data_pos(i));
        assign fix_data[i] = rx_data[i] ^ (flip_en && (syn == DPOS));
    end

    // register result, syndrome and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            syn_o   <= '0;
            fixed_o <= 1'b0;
            fatal_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o  <= fix_data;
                syn_o   <= syn;
                fixed_o <= (status == DS_FIXED);
                fatal_o <= (status == DS_FATAL);
            end
        end
    end

    p_dec_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    p_dec_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);
    p_clean_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && syn == '0) |=> (data_o == $past(rx_data)) && !fatal_o);
    p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !(fixed_o && fatal_o));
    p_fatal_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && status == DS_FATAL) |=> data_o == $past(rx_data));
    p_range_fatal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && par_bad && syn > POS_LAST) |=> fatal_o && !fixed_o);

endmodule

// File: rtl/ecc_secded_unit.sv
`timescale 1ns/1ps
// ecc_secded_unit: encode and decode ports of a SEC-DED code for one
// memory word. The two sides are independent and each has one cycle of
// latency. Check-bit count is derived from the data width.
module ecc_secded_unit #(
    parameter int DATA_W = 8,
    localparam int CHK_W = ecc_pkg::chk_width(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [DATA_W-1:0] enc_data,
    output logic              enc_done,
    output logic [CW_W-1:0]   enc_word,
    input  logic              dec_valid,
    input  logic [CW_W-1:0]   dec_word,
    output logic              dec_done,
    output logic [DATA_W-1:0] dec_data,
    output logic [CHK_W-1:0]  dec_syndrome,
    output logic              dec_corrected,
    output logic              dec_uncorrectable
);

    ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (enc_valid),
        .data_i  (enc_data),
        .valid_o (enc_done),
        .cw_o    (enc_word)
    );

    ecc_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (dec_valid),
        .cw_i    (dec_word),
        .valid_o (dec_done),
        .data_o  (dec_data),
        .syn_o   (dec_syndrome),
        .fixed_o (dec_corrected),
        .fatal_o (dec_uncorrectable)
    );

    p_flags_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !enc_done && !dec_done && !dec_corrected && !dec_uncorrectable);

endmodule

// File: tb/sim_ecc_secded_unit.sv
`timescale 1ns/1ps
module sim_ecc_secded_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid = 1'b0;
    logic [7:0]  enc_data = '0;
    logic        enc_done;
    logic [12:0] enc_word;
    logic        dec_valid = 1'b0;
    logic [12:0] dec_word = '0;
    logic        dec_done;
    logic [7:0]  dec_data;
    logic [3:0]  dec_syndrome;
    logic        dec_corrected;
    logic        dec_uncorrectable;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_secded_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_valid(enc_valid), .enc_data(enc_data),
        .enc_done(enc_done), .enc_word(enc_word),
        .dec_valid(dec_valid), .dec_word(dec_word),
        .dec_done(dec_done), .dec_data(dec_data),
        .dec_syndrome(dec_syndrome), .dec_corrected(dec_corrected),
        .dec_uncorrectable(dec_uncorrectable)
    );

    function automatic int dpos(input int i);
        int t[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        return t[i];
    endfunction

    // codeword per R1/R2
    function automatic logic [12:0] ref_enc(input logic [7:0] d);
        logic [12:0] w;
        logic c;
        w = '0;
        for (int i = 0; i < 8; i++) w[dpos(i)] = d[i];
        for (int k = 0; k < 4; k++) begin
            c = 1'b0;
            for (int i = 0; i < 8; i++) if (((dpos(i) >> k) & 1) == 1) c = c ^ d[i];
            w[1 << k] = c;
        end
        w[0] = ^w[12:1];
        return w;
    endfunction

    function automatic logic [7:0] ref_pull(input logic [12:0] w);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) d[i] = w[dpos(i)];
        return d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one encode+decode, check results next cycle, then idle cycle
    task automatic run(input logic [7:0] d, input logic [12:0] flips,
                       input logic [7:0] xd, input logic [3:0] xs,
                       input logic xf, input logic xu);
        @(negedge clk);
        enc_valid = 1'b1; enc_data = d;
        dec_valid = 1'b1; dec_word = ref_enc(d) ^ flips;
        @(negedge clk);
        chk("R3 enc_done", 32'(enc_done), 32'd1);
        chk("R1 R2 enc_word", 32'(enc_word), 32'(ref_enc(d)));
        chk("R4 dec_done", 32'(dec_done), 32'd1);
        chk("R5 R6 R8 R9 dec_data", 32'(dec_data), 32'(xd));
        chk("R5 R6 dec_syndrome", 32'(dec_syndrome), 32'(xs));
        chk("R6 R7 dec_corrected", 32'(dec_corrected), 32'(xf));
        chk("R8 R9 dec_uncorrectable", 32'(dec_uncorrectable), 32'(xu));
        enc_valid = 1'b0; dec_valid = 1'b0;
        @(negedge clk);
        chk("R3 enc idle", 32'(enc_done), 32'd0);
        chk("R4 dec idle", 32'(dec_done), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [12:0] fl;
        int p, q, mode;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 enc_done", 32'(enc_done), 32'd0);
        chk("R10 dec_done", 32'(dec_done), 32'd0);
        chk("R10 flags", 32'({dec_corrected, dec_uncorrectable}), 32'd0);
        rst_n = 1'b1;

        // directed: R5 clean words
        run(8'h00, 13'h0, 8'h00, 4'd0, 1'b0, 1'b0);
        run(8'hFF, 13'h0, 8'hFF, 4'd0, 1'b0, 1'b0);
        // R6: textbook byte, data bit 2 at position 6
        run(8'b00111001, 13'(1) << 6, 8'b00111001, 4'd6, 1'b1, 1'b0);
        // R7: parity bit only
        run(8'hA5, 13'h1, 8'hA5, 4'd0, 1'b1, 1'b0);
        // R8: two data bits
        fl = (13'(1) << 3) | (13'(1) << 12);
        run(8'h3C, fl, ref_pull(ref_enc(8'h3C) ^ fl), 4'(3 ^ 12), 1'b0, 1'b1);
        // R9: syndrome 13 (check bits 1,4,8) and 15 (positions 3,5,9)
        fl = (13'(1) << 1) | (13'(1) << 4) | (13'(1) << 8);
        run(8'h5A, fl, 8'h5A, 4'd13, 1'b0, 1'b1);
        fl = (13'(1) << 3) | (13'(1) << 5) | (13'(1) << 9);
        run(8'h96, fl, ref_pull(ref_enc(8'h96) ^ fl), 4'd15, 1'b0, 1'b1);
        // every single position, R6
        for (int s = 1; s <= 12; s++) run(8'hC3, 13'(1) << s, 8'hC3, 4'(s), 1'b1, 1'b0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            d = 8'($urandom);
            mode = int'($urandom % 4);
            case (mode)
                0: run(d, 13'h0, d, 4'd0, 1'b0, 1'b0);
                1: begin
                    p = 1 + int'($urandom % 12);
                    run(d, 13'(1) << p, d, 4'(p), 1'b1, 1'b0);
                end
                2: run(d, 13'h1, d, 4'd0, 1'b1, 1'b0);
                default: begin
                    p = int'($urandom % 13);
                    q = (p + 1 + int'($urandom % 12)) % 13;
                    fl = (13'(1) << p) | (13'(1) << q);
                    run(d, fl, ref_pull(ref_enc(d) ^ fl), 4'(p ^ q), 1'b0, 1'b1);
                end
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule